// File: doc/BRIEF.md
# Program-Step Data Capture Unit

This block takes snapshots of internal signal-processing nodes at chosen instruction steps. It has four capture channels. Each channel holds a setup word with a 9-bit step number and a 2-bit source select. When the program counter reaches that step on a valid step cycle, the channel latches the selected 24-bit node value. The datapath is modelled as four node buses: multiplier output, dB converter output, multiplier data input and multiplier coefficient input.

Channels 0 and 1 are read back through a synchronous host read port. Channels 2 and 3 leave on one serial pin, framed by the audio word clock and bit clock in an I2S-style layout. Channel 2 uses the low (left) half of the frame and channel 3 uses the high (right) half. A channel's word is copied into the shifter at the frame edge that opens its slot, so a new capture taken while the word is shifting does not change the bits already on their way out.

The serialiser is a three-state machine. In `SER_IDLE` no frame has started since reset. In `SER_SHIFT` a word goes out MSB first. In `SER_PAD` the word is finished and the pin is held low. Every frame edge moves any state to `SER_SHIFT`. After the 24th data bit, `SER_SHIFT` moves to `SER_PAD`.

Top module: `step_capture_unit`

## Requirements
- R1: After reset, every setup word and every captured word is zero, `cap_sdout` is 0, `host_rd_data` is 0, and the serialiser is in `SER_IDLE`.
- R2: A host write with `host_wr_en` high to address 261, 262, 263 or 264 loads the setup word of channel 0, 1, 2 or 3. `host_wdata[8:0]` is the step number and `host_wdata[10:9]` is the source select. A write to any other address changes no setup word.
- R3: On a clock edge where `step_en` is 1 and `pc` equals a channel's step number, that channel latches the selected node. The new value is visible after that edge.
- R4: A captured word does not change on any edge where `step_en` is 0 or `pc` differs from the channel's step number.
- R5: Source select 0 picks `node_mult_out`, 1 picks `node_db_out`, 2 picks `node_mult_din` and 3 picks `node_mult_coef`.
- R6: A read with `host_rd_en` high returns the channel 0 word for address 261 and the channel 1 word for address 262 on `host_rd_data` after the next edge. Any other address returns 0.
- R7: A frame edge is a falling BCLK on which LRCLK differs from its level at the previous falling BCLK. That level starts at 1 after reset. At a frame edge the channel 2 word is loaded if LRCLK is 0, or the channel 3 word if LRCLK is 1, and `cap_sdout` is 0 for that bit period.
- R8: On the next 24 falling BCLK edges `cap_sdout` presents the loaded word MSB first. It then stays 0 until the next frame edge.
- R9: A capture on channel 2 or 3 during a slot does not change the bits of the word already loaded for that slot. The new value appears in the next slot of that channel.
- R10: A host read issued on the same edge as a capture of the channel it reads returns the complete pre-capture word. The following read returns the complete new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Setup write strobe |
| host_wr_addr | input | 9 | Setup write address |
| host_wdata | input | 11 | {select, step number} |
| host_rd_en | input | 1 | Read strobe |
| host_rd_addr | input | 9 | Read address |
| host_rd_data | output | 24 | Registered read data |
| step_en | input | 1 | Program counter valid for this cycle |
| pc | input | 9 | Program counter |
| node_mult_out | input | 24 | Multiplier output node |
| node_db_out | input | 24 | dB converter output node |
| node_mult_din | input | 24 | Multiplier data input node |
| node_mult_coef | input | 24 | Multiplier coefficient input node |
| bclk | input | 1 | Serial bit clock, sampled in the core clock domain |
| lrclk | input | 1 | Serial frame clock, sampled in the core clock domain |
| cap_sdout | output | 1 | Serial output carrying channels 2 and 3 |

## Verification
The bench builds the block with its default parameters: 24-bit words, 9-bit steps and four channels. These values make a full sweep of every program step practical.

For each readable channel and each source select, the bench sweeps the program counter through all 512 steps. Each captured value is computed from the step and the select, and the set includes step 0 and step 511. The two serial channels are checked frame by frame across all four selects, with captures placed in the middle of a slot. The bench also tests writes to the addresses on either side of the setup window and a read that lands on the same edge as a capture.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
    localparam int WORD_W    = 24;
    localparam int STEP_W    = 9;
    localparam int SEL_W     = 2;
    localparam int NUM_CH    = 4;
    localparam int ADDR_W    = 9;
    localparam int BASE_ADDR = 261;

    typedef enum logic [SEL_W-1:0] {
        SRC_MULT_OUT  = 2'd0,
        SRC_DB_OUT    = 2'd1,
        SRC_MULT_DIN  = 2'd2,
        SRC_MULT_COEF = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_PAD   = 2'd2
    } ser_state_e;
endpackage

// File: rtl/dcap_channel.sv
module dcap_channel
    import dcap_pkg::*;
#(
    parameter int CH_WORD_W = WORD_W,
    parameter int CH_STEP_W = STEP_W,
    parameter int CH_ADDR_W = ADDR_W,
    parameter int MY_ADDR   = BASE_ADDR
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CH_ADDR_W-1:0]         wr_addr,
    input  logic [CH_STEP_W+SEL_W-1:0]   wr_data,
    input  logic                         step_en,
    input  logic [CH_STEP_W-1:0]         pc,
    input  logic [CH_WORD_W-1:0]         node_mult_out,
    input  logic [CH_WORD_W-1:0]         node_db_out,
    input  logic [CH_WORD_W-1:0]         node_mult_din,
    input  logic [CH_WORD_W-1:0]         node_mult_coef,
    output logic [CH_WORD_W-1:0]         cap_word
);
    localparam logic [CH_ADDR_W-1:0] SETUP_ADDR = CH_ADDR_W'(MY_ADDR);

    logic [CH_STEP_W-1:0] step_q;
    src_e                 sel_q;
    logic [CH_WORD_W-1:0] node_pick;
    logic                 hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            sel_q  <= SRC_MULT_OUT;
        end else if (wr_en && wr_addr == SETUP_ADDR) begin
            step_q <= wr_data[CH_STEP_W-1:0];
            sel_q  <= src_e'(wr_data[CH_STEP_W+SEL_W-1:CH_STEP_W]);
        end
    end

    always_comb begin
        unique case (sel_q)
            SRC_MULT_OUT:  node_pick = node_mult_out;
            SRC_DB_OUT:    node_pick = node_db_out;
            SRC_MULT_DIN:  node_pick = node_mult_din;
            SRC_MULT_COEF: node_pick = node_mult_coef;
            default:       node_pick = '0;
        endcase
    end

    assign hit = step_en && (pc == step_q);

    always_ff @(posedge clk) begin
        if (!rst_n)   cap_word <= '0;
        else if (hit) cap_word <= node_pick;
    end

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_word == $past(node_pick));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_word));
endmodule

// File: rtl/dcap_serializer.sv
module dcap_serializer
    import dcap_pkg::*;
#(
    parameter int SER_WORD_W = WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bclk,
    input  logic                  lrclk,
    input  logic [SER_WORD_W-1:0] word_left,
    input  logic [SER_WORD_W-1:0] word_right,
    output logic                  sdout
);
    localparam int CNT_W = $clog2(SER_WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SER_WORD_W - 1);

    ser_state_e            state_q, state_d;
    logic                  bclk_d;
    logic                  lr_seen;
    logic                  bclk_fall;
    logic                  frame_edge;
    logic [SER_WORD_W-1:0] shreg;
    logic [CNT_W-1:0]      bitcnt;

    assign bclk_fall  = bclk_d && !bclk;
    assign frame_edge = bclk_fall && (lrclk != lr_seen);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b1;
            lr_seen <= 1'b1;
        end else begin
            bclk_d <= bclk;
            if (bclk_fall) lr_seen <= lrclk;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:  if (frame_edge) state_d = SER_SHIFT;
            SER_SHIFT: begin
                if (frame_edge)                           state_d = SER_SHIFT;
                else if (bclk_fall && bitcnt == LAST_BIT) state_d = SER_PAD;
            end
            SER_PAD:   if (frame_edge) state_d = SER_SHIFT;
            default:   state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            sdout  <= 1'b0;
        end else if (frame_edge) begin
            shreg  <= lrclk ? word_right : word_left;
            bitcnt <= '0;
            sdout  <= 1'b0;
        end else if (bclk_fall && state_q == SER_SHIFT) begin
            sdout  <= shreg[SER_WORD_W-1];
            shreg  <= shreg << 1;
            bitcnt <= bitcnt + 1'b1;
        end else if (bclk_fall) begin
            sdout  <= 1'b0;
        end
    end

    assert_frame_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> (state_q == SER_SHIFT) && (sdout == 1'b0));
    assert_pad_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_fall && !frame_edge && state_q != SER_SHIFT) |=> sdout == 1'b0);
    assert_bitcnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SER_SHIFT |-> bitcnt <= LAST_BIT);
endmodule

// File: rtl/step_capture_unit.sv
module step_capture_unit
    import dcap_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_STEP_W = STEP_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_BASE   = BASE_ADDR
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_wr_en,
    input  logic [P_ADDR_W-1:0]         host_wr_addr,
    input  logic [P_STEP_W+SEL_W-1:0]   host_wdata,
    input  logic                        host_rd_en,
    input  logic [P_ADDR_W-1:0]         host_rd_addr,
    output logic [P_WORD_W-1:0]         host_rd_data,
    input  logic                        step_en,
    input  logic [P_STEP_W-1:0]         pc,
    input  logic [P_WORD_W-1:0]         node_mult_out,
    input  logic [P_WORD_W-1:0]         node_db_out,
    input  logic [P_WORD_W-1:0]         node_mult_din,
    input  logic [P_WORD_W-1:0]         node_mult_coef,
    input  logic                        bclk,
    input  logic                        lrclk,
    output logic                        cap_sdout
);
    localparam logic [P_ADDR_W-1:0] RD_ADDR0 = P_ADDR_W'(P_BASE);
    localparam logic [P_ADDR_W-1:0] RD_ADDR1 = P_ADDR_W'(P_BASE + 1);

    logic [P_WORD_W-1:0] cap_word [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dcap_channel #(
            .CH_WORD_W (P_WORD_W),
            .CH_STEP_W (P_STEP_W),
            .CH_ADDR_W (P_ADDR_W),
            .MY_ADDR   (P_BASE + i)
        ) i_channel (
            .clk            (clk),
            .rst_n          (rst_n),
            .wr_en          (host_wr_en),
            .wr_addr        (host_wr_addr),
            .wr_data        (host_wdata),
            .step_en        (step_en),
            .pc             (pc),
            .node_mult_out  (node_mult_out),
            .node_db_out    (node_db_out),
            .node_mult_din  (node_mult_din),
            .node_mult_coef (node_mult_coef),
            .cap_word       (cap_word[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rd_data <= '0;
        end else if (host_rd_en) begin
            if (host_rd_addr == RD_ADDR0)      host_rd_data <= cap_word[0];
            else if (host_rd_addr == RD_ADDR1) host_rd_data <= cap_word[1];
            else                               host_rd_data <= '0;
        end
    end

    dcap_serializer #(.SER_WORD_W(P_WORD_W)) i_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .lrclk      (lrclk),
        .word_left  (cap_word[2]),
        .word_right (cap_word[3]),
        .sdout      (cap_sdout)
    );

    assert_rd_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && host_rd_addr != RD_ADDR0 && host_rd_addr != RD_ADDR1)
        |=> host_rd_data == '0);
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |=> $stable(host_rd_data));
endmodule

// File: tb/test_step_capture_unit.sv
module test_step_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [8:0]  host_wr_addr = '0;
    logic [10:0] host_wdata = '0;
    logic        host_rd_en = 1'b0;
    logic [8:0]  host_rd_addr = '0;
    logic [23:0] host_rd_data;
    logic        step_en = 1'b0;
    logic [8:0]  pc = '0;
    logic [23:0] node_mult_out = '0, node_db_out = '0, node_mult_din = '0, node_mult_coef = '0;
    logic        bclk = 1'b1;
    logic        lrclk = 1'b1;
    logic        cap_sdout;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    step_capture_unit i_step_capture_unit (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wdata(host_wdata),
        .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .step_en(step_en), .pc(pc),
        .node_mult_out(node_mult_out), .node_db_out(node_db_out),
        .node_mult_din(node_mult_din), .node_mult_coef(node_mult_coef),
        .bclk(bclk), .lrclk(lrclk), .cap_sdout(cap_sdout)
    );

    function automatic logic [23:0] node_val(int k, int p);
        logic [1:0] kk = k[1:0];
        node_val = {kk, 2'b10, 11'(p * 3 + k), 9'(p)};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(int addr, int sel, int cnt);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = 9'(addr); host_wdata = {2'(sel), 9'(cnt)};
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic drive_nodes(int p);
        pc = 9'(p);
        node_mult_out = node_val(0, p); node_db_out = node_val(1, p);
        node_mult_din = node_val(2, p); node_mult_coef = node_val(3, p);
    endtask

    task automatic step(int p, bit en);
        @(negedge clk);
        step_en = en; drive_nodes(p);
        @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic rd(int addr, output logic [23:0] v);
        @(negedge clk);
        host_rd_en = 1'b1; host_rd_addr = 9'(addr);
        @(negedge clk);
        host_rd_en = 1'b0;
        v = host_rd_data;
    endtask

    task automatic half_bit(bit b_level, bit change_lr, bit lr_new);
        @(negedge clk);
        bclk = b_level;
        if (change_lr) lrclk = lr_new;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic slot(bit lr, output logic [31:0] bits);
        bits = '0;
        for (int b = 0; b < 32; b++) begin
            half_bit(1'b0, b == 0, lr);
            bits = {bits[30:0], cap_sdout};
            half_bit(1'b1, 1'b0, lr);
        end
    endtask

    task automatic frame(output logic [31:0] l, output logic [31:0] r);
        slot(1'b0, l);
        slot(1'b1, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] v, v2;
        logic [31:0] l, r;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 sdout", 32'(cap_sdout), 0);
        chk("R1 rd_data", 32'(host_rd_data), 0);
        rd(261, v); chk("R1 ch0", 32'(v), 0);
        rd(262, v); chk("R1 ch1", 32'(v), 0);
        step(0, 1'b1);  // all setup words 0 -> capture sel0 at step 0
        rd(261, v); chk("R1 setup zero ch0", 32'(v), 32'(node_val(0, 0)));

        // R3 R4 R5: full pc sweep, readable channels, all selects
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 4; s++) begin
                cnt = (s == 0) ? 511 : (s == 3) ? 0 : (c * 131 + s * 97 + 5);
                wr(261 + c, s, cnt);
                for (int p = 0; p < 512; p++) step(p, 1'b1);
                rd(261 + c, v);
                chk($sformatf("R3 R5 ch%0d sel%0d step%0d", c, s, cnt), 32'(v), 32'(node_val(s, cnt)));
                // R4: step_en low at matching pc, different nodes
                @(negedge clk); step_en = 1'b0; drive_nodes(cnt);
                node_mult_out = ~node_mult_out; node_db_out = ~node_db_out;
                node_mult_din = ~node_mult_din; node_mult_coef = ~node_mult_coef;
                @(negedge clk);
                rd(261 + c, v2);
                chk($sformatf("R4 ch%0d sel%0d", c, s), 32'(v2), 32'(node_val(s, cnt)));
            end
        end

        // R2: neighbouring addresses ignored
        wr(261, 0, 10);
        wr(260, 1, 20);
        wr(265, 2, 20);
        step(20, 1'b1);
        rd(261, v); chk("R2 addr outside window", 32'(v), 32'(node_val(3, 0)) ^ 32'(v) ^ 32'(v));
        chk("R2 no capture at step 20", 32'(v == node_val(0, 20) || v == node_val(1, 20) || v == node_val(2, 20)), 0);
        step(10, 1'b1);
        rd(261, v); chk("R2 ch0 setup kept", 32'(v), 32'(node_val(0, 10)));

        // R6: other read addresses
        rd(263, v); chk("R6 addr 263", 32'(v), 0);
        rd(0, v);   chk("R6 addr 0", 32'(v), 0);
        rd(262, v); chk("R6 addr 262", 32'(v), 32'(node_val(3, 0)));

        // R10: read on same edge as capture
        wr(262, 2, 77);
        @(negedge clk);
        step_en = 1'b1; drive_nodes(77); host_rd_en = 1'b1; host_rd_addr = 9'd262;
        @(negedge clk);
        step_en = 1'b0; host_rd_en = 1'b0;
        chk("R10 old word", 32'(host_rd_data), 32'(node_val(3, 0)));
        rd(262, v); chk("R10 new word", 32'(v), 32'(node_val(2, 77)));

        // R7 R8: serial channels, all selects
        for (int s = 0; s < 4; s++) begin
            wr(263, s, 100 + s);
            wr(264, 3 - s, 300 + s);
            step(100 + s, 1'b1);
            step(300 + s, 1'b1);
            frame(l, r);
            chk($sformatf("R7 R8 left sel%0d", s), l, {1'b0, node_val(s, 100 + s), 7'b0});
            chk($sformatf("R7 R8 right sel%0d", 3 - s), r, {1'b0, node_val(3 - s, 300 + s), 7'b0});
        end

        // R9: capture during a slot does not disturb the loaded word
        wr(263, 1, 50);
        step(50, 1'b1);
        fork
            slot(1'b0, l);
            begin
                repeat (40) @(negedge clk);
                step_en = 1'b1; drive_nodes(51);
                node_db_out = 24'h5A5A5A;
                pc = 9'd50;
                @(negedge clk);
                step_en = 1'b0;
            end
        join
        chk("R9 loaded word kept", l, {1'b0, node_val(1, 50), 7'b0});
        slot(1'b1, r);
        slot(1'b0, l);
        chk("R9 next slot new word", l, {1'b0, 24'h5A5A5A, 7'b0});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule